// File: doc/BRIEF.md
# Sector Bit-Error Corrector

This block takes the result of an external BCH decoder for one sector and applies it to the sector held in a byte buffer. When started, it takes a snapshot of a shared error-count word and a set of location words, and selects the 4-bit count that belongs to the requested sector. It then waits for that sector's decode-complete flag.

Once the flag is set, it walks the error locations one per clock cycle. Each location is a 13-bit bit index. It is turned into a byte address and a one-hot bit mask. The result is sent either to the data region (512 bytes) or to the metadata region (8 bytes), and the buffer applies the mask with an exclusive-or. Locations that point into the parity region are dropped.

When the walk ends, a one-cycle completion pulse is raised together with the number of bits actually corrected. A sector whose count carries the reserved "uncorrectable" value is flagged and left untouched.

Top module: `ecc_bitfix`

## Requirements
- R1: The count for sector s is taken from bits 4*s+3 down to 4*s of the count word; the nibbles of other sectors have no effect.
- R2: A selected count of 15 marks the sector uncorrectable: no flip is issued, `uncorr_o` is 1 and `fixed_cnt_o` is 0 when done pulses.
- R3: Location entry i is read from location word i/2; an even i uses bits 12:0 and an odd i uses bits 28:16, and all other bits are ignored.
- R4: A location L below 4096 issues one flip to the data region at byte L>>3, with a mask that has only bit L&7 set (`flip_meta_o` = 0).
- R5: A location L from 4096 to 4159 issues one flip to the metadata region (`flip_meta_o` = 1) at byte (L>>3)-512, with the mask bit L&7.
- R6: A location of 4160 or above issues no flip.
- R7: `fixed_cnt_o` equals the number of the first `count` entries whose location is below 4160, and it holds until the next accepted start.
- R8: No flip is issued and done does not pulse until the decode-complete bit of the selected sector is 1; the bits of other sectors do not release the walk.
- R9: If the start is sampled at edge A and the done bit is first seen at edge B (B > A), entry k is presented in the cycle after edge B+k, and done pulses for exactly one cycle after edge B+count (after edge B for counts 0 and 15).
- R10: A start pulse seen while `busy_o` is 1 is ignored, and changes to the count or location inputs after an accepted start do not alter that run.
- R11: After reset, `busy_o`, `done_o`, `flip_en_o`, `uncorr_o` and `fixed_cnt_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a correction for `sect_i` |
| sect_i | input | SEC_W (3) | Sector number |
| errcnt_word_i | input | N_SECT*4 (32) | Error counts, one nibble per sector |
| loc_words_i | input | LOC_WORDS*32 (224) | Error location words, two entries each |
| dec_done_i | input | N_SECT (8) | Decode-complete flag per sector |
| flip_en_o | output | 1 | Apply a flip this cycle |
| flip_meta_o | output | 1 | 1: metadata region, 0: data region |
| flip_addr_o | output | ADDR_W (9) | Byte address within the region |
| flip_mask_o | output | 8 | One-hot exclusive-or mask |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| uncorr_o | output | 1 | The last run was uncorrectable |
| fixed_cnt_o | output | 4 | Bits corrected in the last run |

## Verification
The walk over the final location entry and the closing of the run fall on the same clock edge. That edge adds the last entry's hit to the corrected count and also raises done. The sweep ends many runs on a data location, a metadata location or a parity location, so the reported count is judged in all three cases against a count worked out from the location values alone.

A second overlap is a fresh start request arriving while a walk is still flipping bits. The bench raises one in mid-run, and at the same moment changes the location and count inputs. It then requires that the buffer image and the count match the original request.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;
   localparam int CNT_W       = 4;
   localparam int WORD_W      = 32;
   localparam int ODD_OFS     = 16;
   localparam int BIT_SEL_W   = 3;
   localparam logic [CNT_W-1:0] CNT_FAIL = 4'hF;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_RUN  = 2'd2
   } fix_state_e;
endpackage

// File: rtl/ecc_loc_pick.sv
module ecc_loc_pick
   import ecc_fix_pkg::*;
#(
   parameter int LOC_WORDS = 7,
   parameter int LOC_W     = 13,
   parameter int IDX_W     = 4
) (
   input  logic [LOC_WORDS*WORD_W-1:0] words_i,
   input  logic [IDX_W-1:0]            idx_i,
   output logic [LOC_W-1:0]            loc_o
);
   localparam int N_ENT  = 2 * LOC_WORDS;
   localparam int N_SLOT = 1 << IDX_W;

   if (LOC_W > ODD_OFS) begin : g_bad_locw
      $error("location width does not fit a half word");
   end
   if (N_SLOT < N_ENT) begin : g_bad_idx
      $error("index width too narrow for the entry count");
   end

   logic [LOC_W-1:0] slot [N_SLOT];

   // even entry low half, odd entry high half of each word
   for (genvar e = 0; e < N_SLOT; e++) begin : g_slot
      if (e < N_ENT) begin : g_real
         localparam int BASE = (e / 2) * WORD_W + (e % 2) * ODD_OFS;
         assign slot[e] = words_i[BASE +: LOC_W];
      end else begin : g_pad
         assign slot[e] = '0;
      end
   end

   logic unused_pad;
   if (LOC_W < ODD_OFS) begin : g_unused
      logic [2*LOC_WORDS*(ODD_OFS-LOC_W)-1:0] pad_bits;
      for (genvar w = 0; w < LOC_WORDS; w++) begin : g_w
         assign pad_bits[(2*w)*(ODD_OFS-LOC_W) +: ODD_OFS-LOC_W]   = words_i[w*WORD_W+LOC_W +: ODD_OFS-LOC_W];
         assign pad_bits[(2*w+1)*(ODD_OFS-LOC_W) +: ODD_OFS-LOC_W] = words_i[w*WORD_W+ODD_OFS+LOC_W +: ODD_OFS-LOC_W];
      end
      assign unused_pad = ^pad_bits;
   end else begin : g_nounused
      assign unused_pad = 1'b0;
   end

   assign loc_o = slot[idx_i];
endmodule

// File: rtl/ecc_loc_steer.sv
module ecc_loc_steer
   import ecc_fix_pkg::*;
#(
   parameter int LOC_W        = 13,
   parameter int SECTOR_BYTES = 512,
   parameter int META_BYTES   = 8
) (
   input  logic [LOC_W-1:0]                    loc_i,
   output logic                                hit_data_o,
   output logic                                hit_meta_o,
   output logic [$clog2(SECTOR_BYTES)-1:0]     addr_o,
   output logic [7:0]                          mask_o
);
   localparam int ADDR_W    = $clog2(SECTOR_BYTES);
   localparam int BYTE_W    = LOC_W - BIT_SEL_W;
   localparam int DATA_BITS = SECTOR_BYTES * 8;
   localparam int META_END  = DATA_BITS + META_BYTES * 8;

   if (META_END > (1 << LOC_W)) begin : g_bad_span
      $error("data plus metadata exceed the location range");
   end
   if (META_BYTES > SECTOR_BYTES || META_BYTES < 1) begin : g_bad_meta
      $error("metadata size out of range");
   end
   if ((1 << ADDR_W) != SECTOR_BYTES) begin : g_bad_sect
      $error("sector size must be a power of two");
   end

   logic [BYTE_W-1:0] byte_idx;
   logic [BYTE_W-1:0] meta_off;

   assign byte_idx   = loc_i[LOC_W-1:BIT_SEL_W];
   assign meta_off   = byte_idx - BYTE_W'(SECTOR_BYTES);
   assign hit_data_o = (loc_i < LOC_W'(DATA_BITS));
   assign hit_meta_o = !hit_data_o && (loc_i < LOC_W'(META_END));
   assign addr_o     = hit_meta_o ? meta_off[ADDR_W-1:0] : byte_idx[ADDR_W-1:0];

   for (genvar b = 0; b < 8; b++) begin : g_mask
      assign mask_o[b] = (loc_i[BIT_SEL_W-1:0] == BIT_SEL_W'(b));
   end

   logic unused_hi;
   assign unused_hi = ^{byte_idx[BYTE_W-1:ADDR_W], meta_off[BYTE_W-1:ADDR_W]};
endmodule

// File: rtl/ecc_bitfix.sv
module ecc_bitfix
   import ecc_fix_pkg::*;
#(
   parameter int N_SECT       = 8,
   parameter int LOC_WORDS    = 7,
   parameter int LOC_W        = 13,
   parameter int SECTOR_BYTES = 512,
   parameter int META_BYTES   = 8,
   localparam int SEC_W       = $clog2(N_SECT),
   localparam int ADDR_W      = $clog2(SECTOR_BYTES)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        start_i,
   input  logic [SEC_W-1:0]            sect_i,
   input  logic [N_SECT*CNT_W-1:0]     errcnt_word_i,
   input  logic [LOC_WORDS*WORD_W-1:0] loc_words_i,
   input  logic [N_SECT-1:0]           dec_done_i,
   output logic                        flip_en_o,
   output logic                        flip_meta_o,
   output logic [ADDR_W-1:0]           flip_addr_o,
   output logic [7:0]                  flip_mask_o,
   output logic                        busy_o,
   output logic                        done_o,
   output logic                        uncorr_o,
   output logic [CNT_W-1:0]            fixed_cnt_o
);
   localparam int IDX_W = $clog2(2 * LOC_WORDS);

   if (N_SECT < 2 || (1 << SEC_W) != N_SECT) begin : g_bad_nsect
      $error("sector count must be a power of two of at least 2");
   end
   if (2 * LOC_WORDS < int'(CNT_FAIL) - 1) begin : g_bad_words
      $error("too few location words for the largest count");
   end

   fix_state_e                  state_q;
   logic [SEC_W-1:0]            sect_q;
   logic [CNT_W-1:0]            cnt_q;
   logic [LOC_WORDS*WORD_W-1:0] words_q;
   logic [IDX_W-1:0]            idx_q;
   logic [CNT_W-1:0]            acc_q;
   logic                        done_q;
   logic                        uncorr_q;
   logic [CNT_W-1:0]            fixed_q;

   logic [LOC_W-1:0] cur_loc;
   logic             hit_data, hit_meta, hit;
   logic [CNT_W-1:0] acc_nx;
   logic             last_ent;
   logic [CNT_W-1:0] cnt_sel;

   ecc_loc_pick #(
      .LOC_WORDS (LOC_WORDS),
      .LOC_W     (LOC_W),
      .IDX_W     (IDX_W)
   ) u_pick (
      .words_i (words_q),
      .idx_i   (idx_q),
      .loc_o   (cur_loc)
   );

   ecc_loc_steer #(
      .LOC_W        (LOC_W),
      .SECTOR_BYTES (SECTOR_BYTES),
      .META_BYTES   (META_BYTES)
   ) u_steer (
      .loc_i      (cur_loc),
      .hit_data_o (hit_data),
      .hit_meta_o (hit_meta),
      .addr_o     (flip_addr_o),
      .mask_o     (flip_mask_o)
   );

   assign cnt_sel  = errcnt_word_i[sect_i*CNT_W +: CNT_W];
   assign hit      = hit_data | hit_meta;
   assign acc_nx   = acc_q + CNT_W'(hit);
   assign last_ent = (32'(cnt_q) == 32'(idx_q) + 32'd1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         sect_q   <= '0;
         cnt_q    <= '0;
         words_q  <= '0;
         idx_q    <= '0;
         acc_q    <= '0;
         done_q   <= 1'b0;
         uncorr_q <= 1'b0;
         fixed_q  <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  sect_q   <= sect_i;
                  cnt_q    <= cnt_sel;
                  words_q  <= loc_words_i;
                  uncorr_q <= 1'b0;
                  fixed_q  <= '0;
                  state_q  <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (dec_done_i[sect_q]) begin
                  idx_q <= '0;
                  acc_q <= '0;
                  if (cnt_q == CNT_FAIL) begin
                     uncorr_q <= 1'b1;
                     done_q   <= 1'b1;
                     state_q  <= ST_IDLE;
                  end else if (cnt_q == '0) begin
                     done_q   <= 1'b1;
                     state_q  <= ST_IDLE;
                  end else begin
                     state_q  <= ST_RUN;
                  end
               end
            end
            ST_RUN: begin
               acc_q <= acc_nx;
               idx_q <= idx_q + IDX_W'(1);
               if (last_ent) begin
                  fixed_q <= acc_nx;
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign flip_en_o   = (state_q == ST_RUN) && hit;
   assign flip_meta_o = hit_meta;
   assign busy_o      = (state_q != ST_IDLE);
   assign done_o      = done_q;
   assign uncorr_o    = uncorr_q;
   assign fixed_cnt_o = fixed_q;

   p_uncorr_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      uncorr_q |-> !flip_en_o);
   p_mask_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      flip_en_o |-> ($countones(flip_mask_o) == 1));
   p_meta_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (flip_en_o && flip_meta_o) |-> (32'(flip_addr_o) < META_BYTES));
   p_fixed_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (fixed_q <= cnt_q));
   p_hold_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WAIT && !dec_done_i[sect_q]) |=> (state_q == ST_WAIT));
   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);
   p_ignore_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> (sect_q == $past(sect_q) && cnt_q == $past(cnt_q)));
endmodule

// File: tb/ecc_bitfix_tb.sv
module ecc_bitfix_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NS = 8;
   localparam int LW = 7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [2:0]    sect_i = '0;
   logic [31:0]   errcnt_word_i = '0;
   logic [LW*32-1:0] loc_words_i = '0;
   logic [NS-1:0] dec_done_i = '0;
   logic          flip_en_o, flip_meta_o, busy_o, done_o, uncorr_o;
   logic [8:0]    flip_addr_o;
   logic [7:0]    flip_mask_o;
   logic [3:0]    fixed_cnt_o;

   int checks = 0;
   int errors = 0;

   logic [7:0] dut_d [512];
   logic [7:0] exp_d [512];
   logic [7:0] dut_m [8];
   logic [7:0] exp_m [8];
   int locs [14];

   always #(CLK_PERIOD/2) clk = ~clk;

   ecc_bitfix u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .sect_i(sect_i),
      .errcnt_word_i(errcnt_word_i), .loc_words_i(loc_words_i),
      .dec_done_i(dec_done_i), .flip_en_o(flip_en_o), .flip_meta_o(flip_meta_o),
      .flip_addr_o(flip_addr_o), .flip_mask_o(flip_mask_o), .busy_o(busy_o),
      .done_o(done_o), .uncorr_o(uncorr_o), .fixed_cnt_o(fixed_cnt_o)
   );

   task automatic check(input bit ok, input string tag, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, expv);
      end
   endtask

   function automatic int gen_loc(input int r, input int j);
      int bnd [10] = '{0, 4095, 4096, 4159, 4160, 8191, 7, 4100, 3, 4158};
      if (r % 4 == 0) return bnd[(j + r / 4) % 10];
      return (r * 977 + j * 1291 + 13) & 8191;
   endfunction

   task automatic run_sector(input int s, input int c, input int r, input int delay, input bit disturb);
      int n;
      int exp_fix;
      int exp_n;
      int early;
      int mism;
      bit seen;
      logic [LW*32-1:0] words_save;
      for (int j = 0; j < 14; j++) locs[j] = gen_loc(r, j);
      // R3: even entry in 12:0, odd in 28:16, filler bits set to one
      for (int w = 0; w < LW; w++)
         loc_words_i[w*32 +: 32] = {3'b111, locs[2*w+1][12:0], 3'b111, locs[2*w][12:0]};
      words_save = loc_words_i;
      // R1: other nibbles carry different counts
      for (int k = 0; k < NS; k++)
         errcnt_word_i[k*4 +: 4] = (k == s) ? 4'(c) : 4'(c + k + 3);
      exp_fix = 0;
      if (c != 15) begin
         for (int j = 0; j < c; j++) begin
            if (locs[j] < 4096) begin
               exp_d[locs[j] >> 3] ^= 8'(1 << (locs[j] & 7));
               exp_fix++;
            end else if (locs[j] < 4160) begin
               exp_m[(locs[j] >> 3) - 512] ^= 8'(1 << (locs[j] & 7));
               exp_fix++;
            end
         end
      end
      dec_done_i = (delay > 0) ? ~(NS'(1) << s) : '1;
      sect_i = 3'(s);
      start_i = 1'b1;
      n = 0; early = 0; seen = 1'b0;
      while (n < 60) begin
         @(negedge clk);
         n++;
         if (n == 1) start_i = 1'b0;
         if (disturb && n == 3) begin
            start_i = 1'b1;
            sect_i = 3'(s + 1);
            loc_words_i = ~words_save;
            errcnt_word_i = ~errcnt_word_i;
         end
         if (disturb && n == 4) start_i = 1'b0;
         if (flip_en_o) begin
            if (n < 2 + delay) early++;
            if (flip_meta_o) dut_m[flip_addr_o[2:0]] ^= flip_mask_o;
            else dut_d[flip_addr_o] ^= flip_mask_o;
         end
         if (n == 1 + delay) dec_done_i = '1;
         if (done_o) begin
            seen = 1'b1;
            break;
         end
      end
      exp_n = 2 + delay + ((c == 0 || c == 15) ? 0 : c);
      check(seen && n == exp_n, "R9 done latency", n, exp_n);
      if (delay > 0) check(early == 0, "R8 flip before done bit", early, 0);
      mism = 0;
      for (int b = 0; b < 512; b++) if (dut_d[b] !== exp_d[b]) mism++;
      for (int b = 0; b < 8; b++) if (dut_m[b] !== exp_m[b]) mism++;
      check(mism == 0, disturb ? "R10 buffer after mid-run start" : "R3/R4/R5/R6 buffer image", mism, 0);
      check(fixed_cnt_o == 4'(exp_fix), "R7 corrected count", fixed_cnt_o, exp_fix);
      check(uncorr_o == (c == 15), "R2 uncorrectable flag", uncorr_o, (c == 15));
      if (c == 15) check(fixed_cnt_o == 0, "R2 count when uncorrectable", fixed_cnt_o, 0);
      @(negedge clk);
      check(done_o == 1'b0 && busy_o == 1'b0, "R9 single done pulse", done_o, 0);
      check(fixed_cnt_o == 4'(exp_fix), "R7 count held", fixed_cnt_o, exp_fix);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual %0d expected %0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int b = 0; b < 512; b++) begin dut_d[b] = 8'(b * 7); exp_d[b] = 8'(b * 7); end
      for (int b = 0; b < 8; b++) begin dut_m[b] = 8'(b + 90); exp_m[b] = 8'(b + 90); end
      repeat (3) @(negedge clk);
      // R11 reset state
      check(busy_o == 0 && done_o == 0 && flip_en_o == 0, "R11 reset controls", {busy_o, done_o, flip_en_o}, 0);
      check(uncorr_o == 0 && fixed_cnt_o == 0, "R11 reset results", {uncorr_o, fixed_cnt_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int s = 0; s < NS; s++) begin
         for (int c = 0; c < 16; c++) begin
            int r;
            r = s * 16 + c;
            run_sector(s, c, r, (r % 5 == 0) ? 3 : 0, (c >= 3 && r % 3 == 0));
         end
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule